// File: doc/BRIEF.md
# Pixel Input Capture with Half-Width Pairing

This block sits at the parallel pixel input of a display transmitter. It watches the incoming pixel clock pair (a true line and a complementary line) on a faster system clock. At the chosen latch events it captures data and delivers one 24-bit pixel per strobe, together with registered DE, HSYNC and VSYNC. In full-width mode a whole pixel is taken on one selected edge of the true clock line. In half-width mode two 12-bit halves are joined into one pixel. The halves come either from both edges of the true clock line (dual-edge) or from the selected edge of the true line followed by the same edge of the complementary line (single-edge).

The configuration has three fields: bus width, dual-edge select and edge polarity. An interface-select input decides whether these fields come from strap inputs or from register fields. The same input also drives the reset of the register-interface controller. A de-skew source mux picks a built-in default, the de-skew pins or the register value. While the default is in use, three general-purpose control inputs are passed through.

The pairing logic is a two-state machine. ST_WAIT_PRI waits for a primary latch event with DE high. On that event it stores the low half and moves to ST_HAVE_LO. ST_HAVE_LO returns to ST_WAIT_PRI in each of these cases:
- a secondary event: the pixel is emitted if DE is high and dropped if DE is low;
- a primary event with DE low;
- a switch to full-width mode.

Top module: `pixin_capture`

## Requirements
- R1: During reset and at its release, pix_vld, pix_out, de_out, hs_out and vs_out are all 0.
- R2: Full-width mode (width=1) captures all 24 bits of data_in on the rising edge of pclk_p when edge=1, or on its falling edge when edge=0. The other edge captures nothing.
- R3: Half-width dual-edge mode (width=0, dual=1) latches on both edges of pclk_p. The primary edge is rising when edge=1 and falling when edge=0. The half taken at the primary edge forms pix_out[11:0], and the half taken at the next secondary edge forms pix_out[23:12]. Only data_in[11:0] is used.
- R4: Half-width single-edge mode (width=0, dual=0) takes the first half on the selected edge of pclk_p and the second half on the same edge of pclk_n. Other transitions capture nothing.
- R5: Pairing starts only at a primary event where de_in is high. A secondary event reached while waiting produces no pixel. pix_vld is only raised together with de_out=1.
- R6: If de_in is low at the secondary event after a stored half, that half is discarded with no strobe. The next pixel pairs from the next primary event.
- R7: In half-width modes, DE, HSYNC and VSYNC are sampled only at the secondary event, and a primary event leaves them unchanged. In full-width mode they are sampled at the capture edge.
- R8: With if_sel=1 the width, dual and edge fields come from reg_*. With if_sel=0 they come from strap_*.
- R9: When width=1 and dual=1 are selected together, cfg_err is 1 and capture behaves as full-width single-edge. Otherwise cfg_err is 0.
- R10: De-skew source selection works as follows. With if_sel=0 and dk_en=0, deskew_val is the default (4) and gp_out equals gp_in. With if_sel=0 and dk_en=1, deskew_val equals dk_pins. With if_sel=1, deskew_val equals reg_dk. In all cases other than the first, gp_out is 0.
- R11: regif_rst_n follows if_sel, so the register-interface controller is held in reset while if_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_sel | input | 1 | 1: configuration from registers, 0: from straps |
| strap_wide | input | 1 | Strap: 1 full-width, 0 half-width |
| strap_dual | input | 1 | Strap: dual-edge select |
| strap_edge | input | 1 | Strap: 1 rising, 0 falling primary edge |
| reg_wide | input | 1 | Register field: width |
| reg_dual | input | 1 | Register field: dual-edge |
| reg_edge | input | 1 | Register field: edge polarity |
| dk_en | input | 1 | De-skew pin enable |
| dk_pins | input | 3 | De-skew setting from pins |
| reg_dk | input | 3 | De-skew setting from registers |
| gp_in | input | 3 | General-purpose control inputs |
| pclk_p | input | 1 | Pixel clock, true line |
| pclk_n | input | 1 | Pixel clock, complementary line |
| data_in | input | 24 | Pixel data bus |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| pix_out | output | 24 | Assembled pixel |
| pix_vld | output | 1 | One-cycle strobe for pix_out |
| de_out | output | 1 | Sampled data enable |
| hs_out | output | 1 | Sampled horizontal sync |
| vs_out | output | 1 | Sampled vertical sync |
| cfg_err | output | 1 | Illegal configuration flag |
| deskew_val | output | 3 | Selected de-skew setting |
| gp_out | output | 3 | Passed general-purpose controls |
| regif_rst_n | output | 1 | Reset for the register-interface controller |

## Verification
A pixel-clock transition is picked up by one input register stage and acted on by one output register. Pixel, strobe and sync results therefore appear two system clock edges after the transition is driven. The bench drives every input on a falling system edge and waits four system cycles after each pixel-clock step before it compares anything. The one-cycle strobe is recorded by a monitor on the falling system edge, so no pulse is missed between checks. The configuration and de-skew outputs are combinational and are compared one cycle after their inputs change.

// File: rtl/pixin_pkg.sv
package pixin_pkg;
    typedef struct packed {
        logic wide;
        logic dual;
        logic edge_rise;
    } pixin_cfg_t;

    typedef enum logic {
        ST_WAIT_PRI = 1'b0,
        ST_HAVE_LO  = 1'b1
    } pair_state_t;
endpackage

// File: rtl/pixin_cfg_mux.sv
module pixin_cfg_mux
    import pixin_pkg::*;
#(
    parameter int DK_W = 3,
    parameter int GP_W = 3,
    parameter logic [DK_W-1:0] DK_DEFAULT = 4
) (
    input  logic            if_sel,
    input  logic            strap_wide,
    input  logic            strap_dual,
    input  logic            strap_edge,
    input  logic            reg_wide,
    input  logic            reg_dual,
    input  logic            reg_edge,
    input  logic            dk_en,
    input  logic [DK_W-1:0] dk_pins,
    input  logic [DK_W-1:0] reg_dk,
    input  logic [GP_W-1:0] gp_in,
    output pixin_cfg_t      cfg,
    output logic            cfg_err,
    output logic [DK_W-1:0] deskew_val,
    output logic [GP_W-1:0] gp_out,
    output logic            regif_rst_n
);
    always_comb begin
        if (if_sel) begin
            cfg.wide      = reg_wide;
            cfg.dual      = reg_dual;
            cfg.edge_rise = reg_edge;
        end else begin
            cfg.wide      = strap_wide;
            cfg.dual      = strap_dual;
            cfg.edge_rise = strap_edge;
        end
    end

    assign cfg_err = cfg.wide & cfg.dual;

    always_comb begin
        gp_out = '0;
        if (if_sel) begin
            deskew_val = reg_dk;
        end else if (dk_en) begin
            deskew_val = dk_pins;
        end else begin
            deskew_val = DK_DEFAULT;
            gp_out     = gp_in;
        end
    end

    assign regif_rst_n = if_sel;
endmodule

// File: rtl/pixin_edge_sense.sv
module pixin_edge_sense #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= line_in[i];
                s2 <= s1;
            end
        end
        assign rise[i] = s1 & ~s2;
        assign fall[i] = ~s1 & s2;
    end
endmodule

// File: rtl/pixin_pair_fsm.sv
module pixin_pair_fsm
    import pixin_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pixin_cfg_t       cfg,
    input  logic             p_rise,
    input  logic             p_fall,
    input  logic             n_rise,
    input  logic             n_fall,
    input  logic [PIX_W-1:0] data,
    input  logic             de,
    input  logic             hs,
    input  logic             vs,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             de_out,
    output logic             hs_out,
    output logic             vs_out
);
    pair_state_t state, nxt;
    logic [HALF_W-1:0] lo_q;
    logic eff_dual, pri_evt, sec_evt, out_evt;

    assign eff_dual = cfg.dual & ~cfg.wide;
    assign pri_evt  = cfg.edge_rise ? p_rise : p_fall;
    always_comb begin
        if (cfg.wide)     sec_evt = 1'b0;
        else if (eff_dual) sec_evt = cfg.edge_rise ? p_fall : p_rise;
        else              sec_evt = cfg.edge_rise ? n_rise : n_fall;
    end
    assign out_evt = cfg.wide ? pri_evt : sec_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_PRI;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_PRI: if (!cfg.wide && pri_evt && de) nxt = ST_HAVE_LO;
            ST_HAVE_LO: begin
                if (cfg.wide)              nxt = ST_WAIT_PRI;
                else if (sec_evt)          nxt = ST_WAIT_PRI;
                else if (pri_evt && !de)   nxt = ST_WAIT_PRI;
            end
            default: nxt = ST_WAIT_PRI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            pix_out <= '0;
            pix_vld <= 1'b0;
            de_out  <= 1'b0;
            hs_out  <= 1'b0;
            vs_out  <= 1'b0;
        end else begin
            pix_vld <= 1'b0;
            if (!cfg.wide && pri_evt && de) lo_q <= data[HALF_W-1:0];
            if (cfg.wide && pri_evt && de) begin
                pix_out <= data;
                pix_vld <= 1'b1;
            end else if (state == ST_HAVE_LO && !cfg.wide && sec_evt && de) begin
                pix_out <= {data[HALF_W-1:0], lo_q};
                pix_vld <= 1'b1;
            end
            if (out_evt) begin
                de_out <= de;
                hs_out <= hs;
                vs_out <= vs;
            end
        end
    end

    AST_VLD_NEEDS_DE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> de_out); // R5
    AST_SYNC_HOLD_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_evt && !cfg.wide && !sec_evt) |=> $stable({de_out, hs_out, vs_out})); // R7
    AST_HALF_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HAVE_LO && !cfg.wide && sec_evt && de) |=> pix_vld); // R3
    AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HAVE_LO && !cfg.wide && sec_evt && !de) |=> (!pix_vld && state == ST_WAIT_PRI)); // R6
    AST_WIDE_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HAVE_LO && cfg.wide) |=> (state == ST_WAIT_PRI)); // R2
endmodule

// File: rtl/pixin_capture.sv
module pixin_capture
    import pixin_pkg::*;
#(
    parameter int HALF_W = 12,
    parameter int DK_W = 3,
    parameter int GP_W = 3,
    parameter logic [DK_W-1:0] DK_DEFAULT = 4,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_sel,
    input  logic             strap_wide,
    input  logic             strap_dual,
    input  logic             strap_edge,
    input  logic             reg_wide,
    input  logic             reg_dual,
    input  logic             reg_edge,
    input  logic             dk_en,
    input  logic [DK_W-1:0]  dk_pins,
    input  logic [DK_W-1:0]  reg_dk,
    input  logic [GP_W-1:0]  gp_in,
    input  logic             pclk_p,
    input  logic             pclk_n,
    input  logic [PIX_W-1:0] data_in,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             de_out,
    output logic             hs_out,
    output logic             vs_out,
    output logic             cfg_err,
    output logic [DK_W-1:0]  deskew_val,
    output logic [GP_W-1:0]  gp_out,
    output logic             regif_rst_n
);
    pixin_cfg_t cfg;
    logic [1:0] rise, fall;
    logic [PIX_W-1:0] data_q;
    logic de_q, hs_q, vs_q;

    pixin_cfg_mux #(.DK_W(DK_W), .GP_W(GP_W), .DK_DEFAULT(DK_DEFAULT)) u_cfg (
        .if_sel(if_sel), .strap_wide(strap_wide), .strap_dual(strap_dual),
        .strap_edge(strap_edge), .reg_wide(reg_wide), .reg_dual(reg_dual),
        .reg_edge(reg_edge), .dk_en(dk_en), .dk_pins(dk_pins), .reg_dk(reg_dk),
        .gp_in(gp_in), .cfg(cfg), .cfg_err(cfg_err), .deskew_val(deskew_val),
        .gp_out(gp_out), .regif_rst_n(regif_rst_n)
    );

    pixin_edge_sense #(.LINES(2)) u_edges (
        .clk(clk), .rst_n(rst_n), .line_in({pclk_n, pclk_p}),
        .rise(rise), .fall(fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            de_q   <= 1'b0;
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
        end else begin
            data_q <= data_in;
            de_q   <= de_in;
            hs_q   <= hs_in;
            vs_q   <= vs_in;
        end
    end

    pixin_pair_fsm #(.HALF_W(HALF_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .p_rise(rise[0]), .p_fall(fall[0]), .n_rise(rise[1]), .n_fall(fall[1]),
        .data(data_q), .de(de_q), .hs(hs_q), .vs(vs_q),
        .pix_out(pix_out), .pix_vld(pix_vld), .de_out(de_out),
        .hs_out(hs_out), .vs_out(vs_out)
    );
endmodule

// File: tb/pixin_capture_test.sv
module pixin_capture_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_sel = 0, strap_wide = 0, strap_dual = 0, strap_edge = 0;
    logic reg_wide = 0, reg_dual = 0, reg_edge = 0, dk_en = 0;
    logic [2:0] dk_pins = 0, reg_dk = 0, gp_in = 0;
    logic pclk_p = 0, pclk_n = 0;
    logic [23:0] data_in = 0;
    logic de_in = 0, hs_in = 0, vs_in = 0;
    logic [23:0] pix_out;
    logic pix_vld, de_out, hs_out, vs_out, cfg_err, regif_rst_n;
    logic [2:0] deskew_val, gp_out;

    int n_checks = 0, n_fail = 0, vld_cnt = 0;
    logic [23:0] last_pix = 0;

    always #10 clk = ~clk;

    pixin_capture uut (
        .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .strap_wide(strap_wide),
        .strap_dual(strap_dual), .strap_edge(strap_edge), .reg_wide(reg_wide),
        .reg_dual(reg_dual), .reg_edge(reg_edge), .dk_en(dk_en), .dk_pins(dk_pins),
        .reg_dk(reg_dk), .gp_in(gp_in), .pclk_p(pclk_p), .pclk_n(pclk_n),
        .data_in(data_in), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
        .pix_out(pix_out), .pix_vld(pix_vld), .de_out(de_out), .hs_out(hs_out),
        .vs_out(vs_out), .cfg_err(cfg_err), .deskew_val(deskew_val),
        .gp_out(gp_out), .regif_rst_n(regif_rst_n)
    );

    always @(negedge clk) begin
        if (pix_vld) begin
            vld_cnt  = vld_cnt + 1;
            last_pix = pix_out;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clkset(input logic p, input logic n);
        @(negedge clk);
        pclk_p = p;
        pclk_n = n;
        waitn(4);
    endtask

    task automatic setd(input logic [23:0] d, input logic de, input logic hs);
        @(negedge clk);
        data_in = d; de_in = de; hs_in = hs;
        waitn(1);
    endtask

    task automatic t_reset;
        chk("R1 pix_vld", pix_vld, 0);
        chk("R1 pix_out", pix_out, 0);
        chk("R1 syncs", {de_out, hs_out, vs_out}, 0);
        chk("R11 regif_rst_n low", regif_rst_n, 0);
    endtask

    task automatic t_wide;
        int c;
        strap_wide = 1; strap_dual = 0; strap_edge = 1;
        clkset(0, 1);
        c = vld_cnt;
        setd(24'hA1B2C3, 1, 0); clkset(1, 0);
        setd(24'h111111, 1, 0); clkset(0, 1);
        chk("R2 rise count", vld_cnt - c, 1);
        chk("R2 rise pixel", last_pix, 24'hA1B2C3);
        strap_edge = 0;
        c = vld_cnt;
        setd(24'h222222, 1, 0); clkset(1, 0);
        setd(24'h5E6F70, 1, 0); clkset(0, 1);
        chk("R2 fall count", vld_cnt - c, 1);
        chk("R2 fall pixel", last_pix, 24'h5E6F70);
        chk("R5 de_out with pixel", de_out, 1);
    endtask

    task automatic t_dual;
        int c;
        setd(0, 0, 0);
        strap_wide = 0; strap_dual = 1; strap_edge = 0;
        clkset(1, 0);
        c = vld_cnt;
        setd(24'hFFF123, 1, 0); clkset(0, 1);
        setd(24'hEEE456, 1, 0); clkset(1, 0);
        chk("R3 fall-primary count", vld_cnt - c, 1);
        chk("R3 fall-primary pixel", last_pix, 24'h456123);
        strap_edge = 1;
        setd(0, 0, 0); clkset(0, 1);
        c = vld_cnt;
        setd(24'h000ABC, 1, 1); clkset(1, 0);
        chk("R7 hs held at primary", hs_out, 0);
        setd(24'h000DEF, 1, 1); clkset(0, 1);
        chk("R7 hs sampled at secondary", hs_out, 1);
        chk("R3 rise-primary pixel", last_pix, 24'hDEFABC);
        chk("R3 rise-primary count", vld_cnt - c, 1);
    endtask

    task automatic t_de_align;
        int c;
        c = vld_cnt;
        setd(24'h000777, 0, 0); clkset(1, 0);
        setd(24'h000888, 1, 0); clkset(0, 1);
        chk("R5 no pixel without DE at primary", vld_cnt - c, 0);
        setd(24'h000333, 1, 0); clkset(1, 0);
        setd(24'h000999, 0, 0); clkset(0, 1);
        chk("R6 partial discarded", vld_cnt - c, 0);
        setd(24'h000321, 1, 0); clkset(1, 0);
        setd(24'h000654, 1, 0); clkset(0, 1);
        chk("R6 restart count", vld_cnt - c, 1);
        chk("R6 restart pixel", last_pix, 24'h654321);
    endtask

    task automatic t_single;
        int c;
        setd(0, 0, 0);
        strap_dual = 0; strap_edge = 0;
        clkset(0, 0);
        c = vld_cnt;
        setd(24'h000A0A, 1, 0); clkset(1, 0);
        clkset(0, 0);
        setd(24'h000B0B, 1, 0); clkset(0, 1);
        chk("R4 n rise ignored", vld_cnt - c, 0);
        clkset(0, 0);
        chk("R4 count", vld_cnt - c, 1);
        chk("R4 pixel", last_pix, 24'hB0BA0A);
    endtask

    task automatic t_cfg;
        int c;
        setd(0, 0, 0);
        clkset(0, 0);
        if_sel = 1; reg_wide = 1; reg_dual = 0; reg_edge = 1; reg_dk = 3'd6;
        strap_wide = 0; strap_dual = 1; strap_edge = 0;
        waitn(1);
        chk("R11 regif_rst_n high", regif_rst_n, 1);
        chk("R10 reg deskew", deskew_val, 6);
        c = vld_cnt;
        setd(24'hC0FFEE, 1, 0); clkset(1, 0);
        chk("R8 register width used", last_pix, 24'hC0FFEE);
        chk("R8 count", vld_cnt - c, 1);
        clkset(0, 0);
        if_sel = 0; strap_wide = 1; strap_dual = 1; strap_edge = 1;
        waitn(1);
        chk("R9 cfg_err", cfg_err, 1);
        c = vld_cnt;
        setd(24'h123456, 1, 0); clkset(1, 0);
        setd(24'h999999, 1, 0); clkset(0, 0);
        chk("R9 single-edge count", vld_cnt - c, 1);
        chk("R9 single-edge pixel", last_pix, 24'h123456);
        strap_dual = 0; waitn(1);
        chk("R9 legal no err", cfg_err, 0);
    endtask

    task automatic t_deskew;
        if_sel = 0; dk_en = 0; gp_in = 3'd5; dk_pins = 3'd2;
        waitn(1);
        chk("R10 default deskew", deskew_val, 4);
        chk("R10 gp pass", gp_out, 5);
        dk_en = 1; waitn(1);
        chk("R10 pin deskew", deskew_val, 2);
        chk("R10 gp blocked", gp_out, 0);
        if_sel = 1; waitn(1);
        chk("R10 gp blocked in reg mode", gp_out, 0);
        if_sel = 0;
    endtask

    initial begin
        fork
            begin
                waitn(3);
                t_reset();
                @(negedge clk); rst_n = 1;
                waitn(2);
                t_reset();
                t_wide();
                t_dual();
                t_de_align();
                t_single();
                t_cfg();
                t_deskew();
            end
            begin
                waitn(100000);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule